// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Flag Register

This block is the arithmetic and logic unit of a small 8-bit accumulator machine. From an accumulator byte, an operand byte and a five-bit operation code it produces a result byte with no register in the path. It also works out the next values of five condition flags: sign, zero, auxiliary carry, parity and carry. The flags live in a register inside the block. When the write strobe is high, a clock edge loads the new flag values. The carry and auxiliary-carry inputs of every operation come from that register.

Each class of operation updates its own set of flags. Add and subtract forms take carry from the ninth bit of the sum or difference. Logic operations clear both carries. Increment and decrement leave both carries as they are. Rotates touch only carry. Accumulator complement changes no flag. A mode input makes the parity flag read zero after arithmetic and increment or decrement operations. Instruction decoding, register storage and memory access sit outside the block. The result is taken to the accumulator or to a register by the surrounding logic.

Top module: `alu8_core`

## Requirements
- R1: While `rstN` is low, all five flag outputs are 0.
- R2: Opcode 0 (add) gives `result = accIn + operand`, and opcode 1 (add with carry) also adds the stored carry. Carry is bit 8 of the 9-bit sum. Auxiliary carry is the carry out of bit 3. Sign is result bit 7, zero is set when the result is 0x00, and parity is set by R6.
- R3: Opcode 2 (subtract) gives `result = accIn - operand`, and opcode 3 (subtract with borrow) also subtracts the stored carry. Carry is the borrow, which is bit 8 of the 9-bit difference. Auxiliary carry is the borrow into bit 4. Sign, zero and parity follow R2.
- R4: Opcode 4 (compare) sets all five flags exactly as opcode 2 would, while `result` equals `accIn`.
- R5: Opcodes 5 (AND), 6 (XOR) and 7 (OR) combine `accIn` with `operand` bit by bit. They clear carry and auxiliary carry. Sign and zero come from the result, and parity is always the true parity, whatever `altMode` is.
- R6: Parity is 1 when the result byte has an even number of 1 bits. When `altMode` is 1, opcodes 0 to 4, 8 and 9 load parity as 0.
- R7: Opcode 8 gives `operand + 1` and opcode 9 gives `operand - 1`, both modulo 256. Sign, zero and parity are updated, and carry and auxiliary carry keep their stored values.
- R8: The rotates act on `accIn` and change only carry. Opcode 10 rotates left and copies bit 7 into both carry and bit 0. Opcode 11 rotates right and copies bit 0 into both carry and bit 7. Opcode 12 rotates left through carry: the old carry goes into bit 0 and bit 7 goes into carry. Opcode 13 rotates right through carry: the old carry goes into bit 7 and bit 0 goes into carry.
- R9: Opcode 14 gives `~accIn` and leaves all flags unchanged. Opcodes 15 and 16 pass `accIn` through. Opcode 15 sets carry to 1 and opcode 16 inverts carry.
- R10: Opcode 17 is decimal adjust, and it works in two steps.
  - Low nibble: 6 is added when the low nibble of `accIn` is above 9 or auxiliary carry is set. Auxiliary carry becomes the carry out of that nibble addition, or 0 when no correction is made.
  - High nibble: 0x60 is then added when the high nibble of the partial sum is above 9, when the partial sum overflowed 8 bits, or when carry was set. Carry becomes 1 if it was already set or if either addition overflowed 8 bits.
  - Flags: sign, zero and true parity come from the final byte.
- R11: When `flagWe` is 0, a clock edge leaves all flags unchanged.
- R12: Opcodes 18 to 31 pass `accIn` to `result` and load the flags with their current values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the flag register |
| opCode | input | 5 | Operation select (codes listed in R2 to R12) |
| accIn | input | 8 | Accumulator byte |
| operand | input | 8 | Second operand; the source byte for increment and decrement |
| flagWe | input | 1 | Flag register load strobe |
| altMode | input | 1 | Forces parity to 0 on arithmetic and increment/decrement |
| result | output | 8 | Combinational result byte |
| flagS | output | 1 | Stored sign flag |
| flagZ | output | 1 | Stored zero flag |
| flagAc | output | 1 | Stored auxiliary-carry flag |
| flagP | output | 1 | Stored parity flag |
| flagCy | output | 1 | Stored carry flag |

## Verification
Directed operand pairs come first.
- Sum and difference: 0x7F plus 1, 0xFF plus 1 and 0 minus 1 separate the sign, zero, carry and nibble-carry paths of add and subtract.
- Chained operations: add-with-carry and subtract-with-borrow run after the stored carry has been set. Increment of 0xFF runs with carry set. These show whether the flag register really feeds the carry input, and whether increment keeps carry.
- Decimal adjust: inputs 0x9A, 0x15 with auxiliary carry set, and 0x99 with carry set test each correction branch.
- Parity mode: the same bytes run with `altMode` set and clear show which operation classes are forced to zero parity.

A long stream of random opcodes then follows. It includes undefined codes and has both `flagWe` and `altMode` toggling. Each step is compared with a behavioural model that carries its own flags forward, so one wrongly held or wrongly updated flag shows up in later operations.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int DATA_W = 8;
  localparam int NIB_W  = 4;
  localparam int OP_W   = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_XOR = 5'd6,  OP_OR  = 5'd7,
    OP_INC = 5'd8,  OP_DEC = 5'd9,  OP_RLC = 5'd10, OP_RRC = 5'd11,
    OP_RAL = 5'd12, OP_RAR = 5'd13, OP_CMA = 5'd14, OP_STC = 5'd15,
    OP_CMC = 5'd16, OP_DAA = 5'd17
  } aluOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       doArith;
    logic       doSub;
    logic       useCy;
    logic       doCmp;
    logic       doLogic;
    logic [1:0] logicSel;  // 0 and, 1 xor, 2 or
    logic       doInc;
    logic       doDec;
    logic       doRot;
    logic [1:0] rotSel;    // 0 left circ, 1 right circ, 2 left thru, 3 right thru
    logic       doCma;
    logic       doStc;
    logic       doCmc;
    logic       doDaa;
  } aluStb_t;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } aluFlags_t;

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output aluStb_t         stb
);

  aluOp_e op;
  assign op = aluOp_e'(opCode);

  always_comb begin
    stb = '0;
    case (op)
      OP_ADD: stb.doArith = 1'b1;
      OP_ADC: begin stb.doArith = 1'b1; stb.useCy = 1'b1; end
      OP_SUB: begin stb.doArith = 1'b1; stb.doSub = 1'b1; end
      OP_SBB: begin stb.doArith = 1'b1; stb.doSub = 1'b1; stb.useCy = 1'b1; end
      OP_CMP: begin stb.doArith = 1'b1; stb.doSub = 1'b1; stb.doCmp = 1'b1; end
      OP_AND: begin stb.doLogic = 1'b1; stb.logicSel = 2'd0; end
      OP_XOR: begin stb.doLogic = 1'b1; stb.logicSel = 2'd1; end
      OP_OR:  begin stb.doLogic = 1'b1; stb.logicSel = 2'd2; end
      OP_INC: stb.doInc = 1'b1;
      OP_DEC: stb.doDec = 1'b1;
      OP_RLC: begin stb.doRot = 1'b1; stb.rotSel = 2'd0; end
      OP_RRC: begin stb.doRot = 1'b1; stb.rotSel = 2'd1; end
      OP_RAL: begin stb.doRot = 1'b1; stb.rotSel = 2'd2; end
      OP_RAR: begin stb.doRot = 1'b1; stb.rotSel = 2'd3; end
      OP_CMA: stb.doCma = 1'b1;
      OP_STC: stb.doStc = 1'b1;
      OP_CMC: stb.doCmc = 1'b1;
      OP_DAA: stb.doDaa = 1'b1;
      default: stb = '0;
    endcase
  end

  // at most one operation class active
  always_comb begin
    class_onehot_chk: assert ($onehot0({stb.doArith, stb.doLogic, stb.doInc, stb.doDec,
                                        stb.doRot, stb.doCma, stb.doStc, stb.doCmc,
                                        stb.doDaa}));
  end

endmodule

// File: rtl/alu8_dp.sv
module alu8_dp
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  aluStb_t           stb,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operand,
  input  logic              flagWe,
  input  logic              altMode,
  output logic [DATA_W-1:0] result,
  output aluFlags_t         flagQ
);

  aluFlags_t         nextF;
  logic [DATA_W:0]   sum9;
  logic [NIB_W:0]    nib5;
  logic [DATA_W:0]   daa1;
  logic [DATA_W:0]   daa2;
  logic [DATA_W-1:0] tmp;
  logic              cin;
  logic              lowAdj;
  logic              hiAdj;

  always_comb begin
    result = accIn;
    nextF  = flagQ;
    cin    = stb.useCy & flagQ.cy;
    sum9   = '0;
    nib5   = '0;
    daa1   = '0;
    daa2   = '0;
    tmp    = '0;
    lowAdj = 1'b0;
    hiAdj  = 1'b0;

    if (stb.doArith) begin
      if (stb.doSub) begin
        sum9 = {1'b0, accIn} - {1'b0, operand} - {{DATA_W{1'b0}}, cin};
        nib5 = {1'b0, accIn[NIB_W-1:0]} - {1'b0, operand[NIB_W-1:0]} - {{NIB_W{1'b0}}, cin};
      end else begin
        sum9 = {1'b0, accIn} + {1'b0, operand} + {{DATA_W{1'b0}}, cin};
        nib5 = {1'b0, accIn[NIB_W-1:0]} + {1'b0, operand[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
      end
      if (!stb.doCmp) result = sum9[DATA_W-1:0];
      nextF.cy = sum9[DATA_W];
      nextF.ac = nib5[NIB_W];
      nextF.s  = sum9[DATA_W-1];
      nextF.z  = (sum9[DATA_W-1:0] == '0);
      nextF.p  = altMode ? 1'b0 : ~^sum9[DATA_W-1:0];
    end

    if (stb.doLogic) begin
      case (stb.logicSel)
        2'd0:    tmp = accIn & operand;
        2'd1:    tmp = accIn ^ operand;
        default: tmp = accIn | operand;
      endcase
      result   = tmp;
      nextF.cy = 1'b0;
      nextF.ac = 1'b0;
      nextF.s  = tmp[DATA_W-1];
      nextF.z  = (tmp == '0);
      nextF.p  = ~^tmp;
    end

    if (stb.doInc || stb.doDec) begin
      tmp     = stb.doInc ? operand + 1'b1 : operand - 1'b1;
      result  = tmp;
      nextF.s = tmp[DATA_W-1];
      nextF.z = (tmp == '0);
      nextF.p = altMode ? 1'b0 : ~^tmp;
    end

    if (stb.doRot) begin
      case (stb.rotSel)
        2'd0: begin result = {accIn[DATA_W-2:0], accIn[DATA_W-1]}; nextF.cy = accIn[DATA_W-1]; end
        2'd1: begin result = {accIn[0], accIn[DATA_W-1:1]};        nextF.cy = accIn[0]; end
        2'd2: begin result = {accIn[DATA_W-2:0], flagQ.cy};        nextF.cy = accIn[DATA_W-1]; end
        default: begin result = {flagQ.cy, accIn[DATA_W-1:1]};     nextF.cy = accIn[0]; end
      endcase
    end

    if (stb.doCma) result = ~accIn;
    if (stb.doStc) nextF.cy = 1'b1;
    if (stb.doCmc) nextF.cy = ~flagQ.cy;

    if (stb.doDaa) begin
      lowAdj   = (accIn[NIB_W-1:0] > 4'd9) || flagQ.ac;
      nib5     = {1'b0, accIn[NIB_W-1:0]} + 5'd6;
      daa1     = {1'b0, accIn} + (lowAdj ? 9'd6 : 9'd0);
      hiAdj    = (daa1[DATA_W-1:NIB_W] > 4'd9) || daa1[DATA_W] || flagQ.cy;
      daa2     = {1'b0, daa1[DATA_W-1:0]} + (hiAdj ? 9'h060 : 9'h000);
      result   = daa2[DATA_W-1:0];
      nextF.ac = lowAdj & nib5[NIB_W];
      nextF.cy = flagQ.cy | daa1[DATA_W] | daa2[DATA_W];
      nextF.s  = daa2[DATA_W-1];
      nextF.z  = (daa2[DATA_W-1:0] == '0);
      nextF.p  = ~^daa2[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       flagQ <= '0;
    else if (flagWe) flagQ <= nextF;
  end

  // R11
  we_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flagWe |=> flagQ == $past(flagQ));

  // R7
  incdec_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagWe && (stb.doInc || stb.doDec) |=> flagQ.cy == $past(flagQ.cy) && flagQ.ac == $past(flagQ.ac));

  // R5
  logic_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagWe && stb.doLogic |=> !flagQ.cy && !flagQ.ac);

  // R6
  alt_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagWe && altMode && (stb.doArith || stb.doInc || stb.doDec) |=> !flagQ.p);

  // R4
  cmp_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.doCmp |-> result == accIn);

  // R9
  cma_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagWe && stb.doCma |=> $stable(flagQ));

  // R9
  stc_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagWe && stb.doStc |=> flagQ.cy);

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operand,
  input  logic              flagWe,
  input  logic              altMode,
  output logic [DATA_W-1:0] result,
  output logic              flagS,
  output logic              flagZ,
  output logic              flagAc,
  output logic              flagP,
  output logic              flagCy
);

  aluStb_t   stb;
  aluFlags_t flags;

  alu8_ctrl u_ctrl (
    .opCode (opCode),
    .stb    (stb)
  );

  alu8_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .accIn   (accIn),
    .operand (operand),
    .flagWe  (flagWe),
    .altMode (altMode),
    .result  (result),
    .flagQ   (flags)
  );

  assign flagS  = flags.s;
  assign flagZ  = flags.z;
  assign flagAc = flags.ac;
  assign flagP  = flags.p;
  assign flagCy = flags.cy;

endmodule

// File: tb/alu8_core_test.sv
`timescale 1ns/1ps
module alu8_core_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] opCode = '0;
  logic [7:0] accIn = '0;
  logic [7:0] operand = '0;
  logic       flagWe = 1'b0;
  logic       altMode = 1'b0;
  logic [7:0] result;
  logic       flagS, flagZ, flagAc, flagP, flagCy;

  int checks = 0;
  int errors = 0;
  int ms = 0, mz = 0, mac = 0, mp = 0, mcy = 0;

  always #10 clk = ~clk;

  alu8_core uut (
    .clk(clk), .rstN(rstN), .opCode(opCode), .accIn(accIn), .operand(operand),
    .flagWe(flagWe), .altMode(altMode), .result(result),
    .flagS(flagS), .flagZ(flagZ), .flagAc(flagAc), .flagP(flagP), .flagCy(flagCy)
  );

  function automatic int evenPar(input int v);
    logic [7:0] b;
    b = v[7:0];
    return ($countones(b) % 2 == 0) ? 1 : 0;
  endfunction

  function automatic string tagOf(input int op, input int we, input int alt, input bit isFlag);
    if (isFlag && we == 0) return "R11";
    if (isFlag && alt != 0 && (op <= 4 || op == 8 || op == 9)) return "R6";
    case (op)
      0, 1: return "R2";
      2, 3: return "R3";
      4: return "R4";
      5, 6, 7: return "R5";
      8, 9: return "R7";
      10, 11, 12, 13: return "R8";
      14, 15, 16: return "R9";
      17: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model(input int op, input int a, input int b, input int alt,
                       output int r, output int ns, output int nz, output int nac,
                       output int np, output int ncy);
    int t, lo, c, la, s1, s2, ha;
    r = a; ns = ms; nz = mz; nac = mac; np = mp; ncy = mcy;
    case (op)
      0, 1, 2, 3, 4: begin
        c = (op == 1 || op == 3) ? mcy : 0;
        if (op <= 1) begin
          t = a + b + c; lo = (a % 16) + (b % 16) + c; nac = (lo > 15) ? 1 : 0;
        end else begin
          t = a - b - c; lo = (a % 16) - (b % 16) - c; nac = (lo < 0) ? 1 : 0;
        end
        ncy = (t > 255 || t < 0) ? 1 : 0;
        t = t & 255;
        if (op != 4) r = t;
        ns = (t >= 128) ? 1 : 0; nz = (t == 0) ? 1 : 0;
        np = (alt != 0) ? 0 : evenPar(t);
      end
      5, 6, 7: begin
        r = (op == 5) ? (a & b) : (op == 6) ? (a ^ b) : (a | b);
        ncy = 0; nac = 0; ns = (r >= 128) ? 1 : 0; nz = (r == 0) ? 1 : 0; np = evenPar(r);
      end
      8, 9: begin
        r = (op == 8) ? ((b + 1) & 255) : ((b + 255) & 255);
        ns = (r >= 128) ? 1 : 0; nz = (r == 0) ? 1 : 0;
        np = (alt != 0) ? 0 : evenPar(r);
      end
      10: begin ncy = a / 128; r = ((a * 2) & 255) + a / 128; end
      11: begin ncy = a % 2; r = a / 2 + (a % 2) * 128; end
      12: begin ncy = a / 128; r = ((a * 2) & 255) + mcy; end
      13: begin ncy = a % 2; r = a / 2 + mcy * 128; end
      14: r = 255 - a;
      15: ncy = 1;
      16: ncy = 1 - mcy;
      17: begin
        la = ((a % 16) > 9 || mac != 0) ? 1 : 0;
        s1 = a + (la != 0 ? 6 : 0);
        nac = (la != 0 && (a % 16) + 6 > 15) ? 1 : 0;
        ha = (((s1 / 16) % 16) > 9 || s1 > 255 || mcy != 0) ? 1 : 0;
        s2 = (s1 & 255) + (ha != 0 ? 96 : 0);
        ncy = (mcy != 0 || s1 > 255 || s2 > 255) ? 1 : 0;
        r = s2 & 255;
        ns = (r >= 128) ? 1 : 0; nz = (r == 0) ? 1 : 0; np = evenPar(r);
      end
      default: ;
    endcase
  endtask

  task automatic runOp(input int op, input int a, input int b, input int we, input int alt);
    int r, ns, nz, nac, np, ncy;
    @(negedge clk);
    opCode = op[4:0]; accIn = a[7:0]; operand = b[7:0];
    flagWe = (we != 0); altMode = (alt != 0);
    #5;
    model(op, a, b, alt, r, ns, nz, nac, np, ncy);
    check(tagOf(op, we, alt, 1'b0), "result", int'(result), r);
    @(posedge clk);
    if (we != 0) begin ms = ns; mz = nz; mac = nac; mp = np; mcy = ncy; end
    #2;
    check(tagOf(op, we, alt, 1'b1), "flags SZAPC",
          int'({flagS, flagZ, flagAc, flagP, flagCy}),
          ms * 16 + mz * 8 + mac * 4 + mp * 2 + mcy);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #35;
    // R1 reset state
    check("R1", "flags in reset", int'({flagS, flagZ, flagAc, flagP, flagCy}), 0);
    @(negedge clk); rstN = 1'b1;

    runOp(0, 8'h7F, 8'h01, 1, 0);   // R2 sign + nibble carry
    runOp(0, 8'hFF, 8'h01, 1, 0);   // R2 zero + carry
    runOp(1, 8'h10, 8'h20, 1, 0);   // R2 add with stored carry
    runOp(2, 8'h00, 8'h01, 1, 0);   // R3 borrow
    runOp(3, 8'h50, 8'h10, 1, 0);   // R3 subtract with borrow
    runOp(4, 8'h42, 8'h42, 1, 0);   // R4 equal compare
    runOp(4, 8'h10, 8'h20, 1, 0);   // R4 less than
    runOp(15, 8'h00, 8'h00, 1, 0);  // R9 set carry
    runOp(5, 8'hF0, 8'h3C, 1, 0);   // R5 and
    runOp(15, 8'h00, 8'h00, 1, 0);
    runOp(6, 8'hAA, 8'hAA, 1, 1);   // R5 xor, alt does not matter
    runOp(7, 8'h01, 8'h02, 1, 0);   // R5 or
    runOp(15, 8'h00, 8'h00, 1, 0);
    runOp(8, 8'h00, 8'hFF, 1, 0);   // R7 inc wraps, keeps carry
    runOp(9, 8'h00, 8'h00, 1, 0);   // R7 dec wraps
    runOp(0, 8'h01, 8'h02, 1, 1);   // R6 forced parity zero
    runOp(8, 8'h00, 8'h02, 1, 1);   // R6 inc forced parity zero
    runOp(10, 8'h81, 8'h00, 1, 0);  // R8 rotates
    runOp(11, 8'h01, 8'h00, 1, 0);
    runOp(12, 8'h40, 8'h00, 1, 0);
    runOp(13, 8'h02, 8'h00, 1, 0);
    runOp(14, 8'h5A, 8'h00, 1, 0);  // R9 complement
    runOp(16, 8'h00, 8'h00, 1, 0);  // R9 complement carry
    runOp(16, 8'h00, 8'h00, 1, 0);
    runOp(2, 8'h00, 8'h00, 1, 0);   // clear carries
    runOp(17, 8'h9A, 8'h00, 1, 0);  // R10 both nibbles adjust
    runOp(0, 8'h08, 8'h08, 1, 0);   // sets aux carry
    runOp(17, 8'h15, 8'h00, 1, 0);  // R10 aux carry path
    runOp(15, 8'h00, 8'h00, 1, 0);
    runOp(17, 8'h99, 8'h00, 1, 0);  // R10 carry path
    runOp(0, 8'hFF, 8'hFF, 0, 0);   // R11 no write
    runOp(20, 8'h33, 8'h77, 1, 0);  // R12 undefined code
    runOp(31, 8'hC3, 8'h00, 1, 1);

    for (int i = 0; i < 600; i++) begin
      runOp(int'($urandom_range(0, 21)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), ($urandom_range(0, 7) != 0) ? 1 : 0,
            int'($urandom_range(0, 1)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule